// File: doc/BRIEF.md
# Pause Flow-Control Resolver

This block settles which pause flow-control directions a MAC should use once link is up. It takes the locally requested mode, the PAUSE and asymmetric-direction advertisement bits of both ends, a strict-standard option, the negotiated duplex and an indication that link was forced because negotiation failed. On a one-cycle resolve strobe it computes the effective mode and registers it. It then drives the transmit-pause and receive-pause enables and the receive threshold values that go with that mode.

Resolution first applies the standard pause resolution table. If no table row matches, a lenient fallback selects receive-only pause. Two overrides follow. A full result is reduced to receive-only when the request was anything other than full. Half duplex forces everything to none. On a forced link the table is bypassed and the request is applied directly. Request codes outside the defined set raise a configuration error and leave every output register as it was.

Top module: `pause_fc_resolver`

## Requirements
- R1: After synchronous reset the mode is 0, both enables are low, the error flag is low and both threshold outputs are zero.
- R2: Mode codes are 0 none, 1 receive-only, 2 transmit-only, 3 full. The transmit enable equals mode bit 1 and the receive enable equals mode bit 0. Request codes 0 to 3 use the same meaning, and request code 4 (default) is treated as a full request.
- R3: When both ends advertise PAUSE, the result is full if the request is full or default, and receive-only otherwise.
- R4: When local PAUSE=0, local asym=1, partner PAUSE=1 and partner asym=1, the result is transmit-only.
- R5: When local PAUSE=1, local asym=1, partner PAUSE=0 and partner asym=1, the result is receive-only.
- R6: For every other advertisement combination, the result is none if the request is none or transmit-only, or if strict mode is set. Otherwise the result is receive-only.
- R7: On a negotiated link (not forced) with half duplex, the result is none whatever the table gives.
- R8: When the forced input is high, the mode is taken from the request. The advertisement bits, strict mode and duplex are then ignored.
- R9: A request code of 5, 6 or 7 sets the error flag and leaves mode, enables and thresholds unchanged. A strobe with a valid request clears the flag.
- R10: While the transmit enable is high, the low threshold output is {xon_en, low_water} and the high threshold output is high_water. Otherwise both are zero.
- R11: All outputs change only on the clock edge where the resolve strobe is sampled high, and hold their value at every other edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| resolve_i | input | 1 | One-cycle resolve strobe |
| req_mode_i | input | 3 | Requested mode code (0-3, 4 default, 5-7 invalid) |
| loc_pause_i | input | 1 | Local PAUSE advertisement |
| loc_asym_i | input | 1 | Local asymmetric-direction advertisement |
| lp_pause_i | input | 1 | Partner PAUSE advertisement |
| lp_asym_i | input | 1 | Partner asymmetric-direction advertisement |
| strict_i | input | 1 | Disable the lenient receive-only fallback |
| full_duplex_i | input | 1 | Negotiated duplex, 1 = full |
| forced_i | input | 1 | Link forced after negotiation failure |
| xon_en_i | input | 1 | XON enable flag merged into the low threshold |
| low_water_i | input | THR_W | Low receive threshold |
| high_water_i | input | THR_W | High receive threshold |
| mode_o | output | 2 | Resolved mode |
| tx_pause_o | output | 1 | Transmit pause enable |
| rx_pause_o | output | 1 | Receive pause enable |
| cfg_err_o | output | 1 | Invalid request seen at the last strobe |
| rx_thr_lo_o | output | THR_W+1 | Low threshold, XON flag in the top bit |
| rx_thr_hi_o | output | THR_W | High threshold |

## Verification
A wrong state in the mode register shows on the two enables and the threshold outputs one clock after the strobe that loaded it. It then stays there until the next strobe, so every strobe result can be compared once and then checked again for holding. A missed override, such as half duplex or the full-to-receive-only reduction, shows as a non-zero or wrong mode code. A lost error hold shows as enables that moved on an invalid request. Random advertisement, request and duplex patterns cover the whole table. Directed cases target the fallback, strict mode, the forced path and the invalid codes.

// File: rtl/pause_fc_pkg.sv
package pause_fc_pkg;
  typedef enum logic [1:0] {
    FC_NONE = 2'd0,
    FC_RX   = 2'd1,
    FC_TX   = 2'd2,
    FC_FULL = 2'd3
  } fc_mode_t;

  localparam logic [2:0] REQ_DEFAULT = 3'd4;
endpackage

// File: rtl/fc_resolve_table.sv
module fc_resolve_table
  import pause_fc_pkg::*;
(
  input  logic [2:0] req_mode_i,
  input  logic       loc_pause_i,
  input  logic       loc_asym_i,
  input  logic       lp_pause_i,
  input  logic       lp_asym_i,
  input  logic       strict_i,
  input  logic       full_duplex_i,
  input  logic       forced_i,
  output fc_mode_t   mode_o,
  output logic       valid_o
);
  fc_mode_t req_eff;
  fc_mode_t table_res;

  always_comb begin
    valid_o = (req_mode_i <= REQ_DEFAULT);
    req_eff = (req_mode_i == REQ_DEFAULT) ? FC_FULL : fc_mode_t'(req_mode_i[1:0]);
  end

  // standard resolution, then lenient fallback
  always_comb begin
    if (loc_pause_i && lp_pause_i)
      table_res = (req_eff == FC_FULL) ? FC_FULL : FC_RX;
    else if (!loc_pause_i && loc_asym_i && lp_pause_i && lp_asym_i)
      table_res = FC_TX;
    else if (loc_pause_i && loc_asym_i && !lp_pause_i && lp_asym_i)
      table_res = FC_RX;
    else if (req_eff == FC_NONE || req_eff == FC_TX || strict_i)
      table_res = FC_NONE;
    else
      table_res = FC_RX;
  end

  always_comb begin
    if (forced_i)
      mode_o = req_eff;
    else if (!full_duplex_i)
      mode_o = FC_NONE;
    else
      mode_o = table_res;
  end
endmodule

// File: rtl/fc_enable_decode.sv
module fc_enable_decode
  import pause_fc_pkg::*;
#(
  parameter int THR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  fc_mode_t         mode_i,
  input  logic             xon_en_i,
  input  logic [THR_W-1:0] low_water_i,
  input  logic [THR_W-1:0] high_water_i,
  output logic             tx_pause_o,
  output logic             rx_pause_o,
  output logic [THR_W:0]   thr_lo_o,
  output logic [THR_W-1:0] thr_hi_o
);
  logic tx_next, rx_next;

  always_comb begin
    tx_next = (mode_i == FC_TX) || (mode_i == FC_FULL);
    rx_next = (mode_i == FC_RX) || (mode_i == FC_FULL);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_pause_o <= 1'b0;
      rx_pause_o <= 1'b0;
      thr_lo_o   <= '0;
      thr_hi_o   <= '0;
    end else if (load_i) begin
      tx_pause_o <= tx_next;
      rx_pause_o <= rx_next;
      thr_lo_o   <= tx_next ? {xon_en_i, low_water_i} : '0;
      thr_hi_o   <= tx_next ? high_water_i : '0;
    end
  end

  a_r10_thr_zero: assert property (@(posedge clk) disable iff (rst)
    !tx_pause_o |-> (thr_lo_o == '0 && thr_hi_o == '0));
endmodule

// File: rtl/pause_fc_resolver.sv
module pause_fc_resolver
  import pause_fc_pkg::*;
#(
  parameter int THR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             resolve_i,
  input  logic [2:0]       req_mode_i,
  input  logic             loc_pause_i,
  input  logic             loc_asym_i,
  input  logic             lp_pause_i,
  input  logic             lp_asym_i,
  input  logic             strict_i,
  input  logic             full_duplex_i,
  input  logic             forced_i,
  input  logic             xon_en_i,
  input  logic [THR_W-1:0] low_water_i,
  input  logic [THR_W-1:0] high_water_i,
  output logic [1:0]       mode_o,
  output logic             tx_pause_o,
  output logic             rx_pause_o,
  output logic             cfg_err_o,
  output logic [THR_W:0]   rx_thr_lo_o,
  output logic [THR_W-1:0] rx_thr_hi_o
);
  fc_mode_t next_mode;
  fc_mode_t mode_q;
  logic     req_ok;
  logic     load;

  fc_resolve_table u_table (
    .req_mode_i   (req_mode_i),
    .loc_pause_i  (loc_pause_i),
    .loc_asym_i   (loc_asym_i),
    .lp_pause_i   (lp_pause_i),
    .lp_asym_i    (lp_asym_i),
    .strict_i     (strict_i),
    .full_duplex_i(full_duplex_i),
    .forced_i     (forced_i),
    .mode_o       (next_mode),
    .valid_o      (req_ok)
  );

  assign load = resolve_i && req_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= FC_NONE;
      cfg_err_o <= 1'b0;
    end else if (resolve_i) begin
      cfg_err_o <= !req_ok;
      if (req_ok) mode_q <= next_mode;
    end
  end

  assign mode_o = mode_q;

  fc_enable_decode #(.THR_W(THR_W)) u_dec (
    .clk         (clk),
    .rst         (rst),
    .load_i      (load),
    .mode_i      (next_mode),
    .xon_en_i    (xon_en_i),
    .low_water_i (low_water_i),
    .high_water_i(high_water_i),
    .tx_pause_o  (tx_pause_o),
    .rx_pause_o  (rx_pause_o),
    .thr_lo_o    (rx_thr_lo_o),
    .thr_hi_o    (rx_thr_hi_o)
  );

  a_r2_enables_match: assert property (@(posedge clk) disable iff (rst)
    (tx_pause_o == mode_o[1]) && (rx_pause_o == mode_o[0]));

  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    !resolve_i |=> ($stable(mode_o) && $stable(tx_pause_o) && $stable(rx_pause_o)
                    && $stable(cfg_err_o)));

  a_r9_err_hold: assert property (@(posedge clk) disable iff (rst)
    (resolve_i && req_mode_i > 3'd4) |=> (cfg_err_o && $stable(mode_o) && $stable(rx_thr_lo_o)));

  a_r7_half_none: assert property (@(posedge clk) disable iff (rst)
    (resolve_i && !forced_i && req_mode_i <= 3'd4 && !full_duplex_i) |=>
      (mode_o == 2'd0 && !tx_pause_o && !rx_pause_o));

  a_r4_tx_only: assert property (@(posedge clk) disable iff (rst)
    (resolve_i && !forced_i && full_duplex_i && req_mode_i <= 3'd4 &&
     !loc_pause_i && loc_asym_i && lp_pause_i && lp_asym_i) |=> (mode_o == 2'd2));
endmodule

// File: tb/test_pause_fc_resolver.sv
module test_pause_fc_resolver;
  localparam int THR_W = 16;

  logic clk = 1'b0;
  logic rst;
  logic resolve;
  logic [2:0] req;
  logic lpz, lasy, ppz, pasy, strict, fdx, forced, xon;
  logic [THR_W-1:0] lw, hw;
  logic [1:0] mode;
  logic tx_en, rx_en, err;
  logic [THR_W:0] thr_lo;
  logic [THR_W-1:0] thr_hi;

  int checks = 0;
  int errors = 0;
  logic [1:0] e_mode;
  logic e_err;
  logic [THR_W:0] e_lo;
  logic [THR_W-1:0] e_hi;

  always #10 clk = ~clk;

  pause_fc_resolver #(.THR_W(THR_W)) i_pause_fc_resolver (
    .clk(clk), .rst(rst), .resolve_i(resolve), .req_mode_i(req),
    .loc_pause_i(lpz), .loc_asym_i(lasy), .lp_pause_i(ppz), .lp_asym_i(pasy),
    .strict_i(strict), .full_duplex_i(fdx), .forced_i(forced), .xon_en_i(xon),
    .low_water_i(lw), .high_water_i(hw), .mode_o(mode), .tx_pause_o(tx_en),
    .rx_pause_o(rx_en), .cfg_err_o(err), .rx_thr_lo_o(thr_lo), .rx_thr_hi_o(thr_hi)
  );

  function automatic logic [1:0] model(input logic [2:0] r, input logic a, b, c, d,
                                       input logic s, f, frc);
    logic [1:0] q;
    logic [1:0] res;
    q = (r == 3'd4) ? 2'd3 : r[1:0];
    if (a && c)                    res = (q == 2'd3) ? 2'd3 : 2'd1;
    else if (!a && b && c && d)    res = 2'd2;
    else if (a && b && !c && d)    res = 2'd1;
    else if (q == 2'd0 || q == 2'd2 || s) res = 2'd0;
    else                           res = 2'd1;
    if (frc) return q;
    if (!f) return 2'd0;
    return res;
  endfunction

  task automatic check(input string tag);
    checks++;
    if (mode !== e_mode || tx_en !== e_mode[1] || rx_en !== e_mode[0] || err !== e_err ||
        thr_lo !== e_lo || thr_hi !== e_hi) begin
      errors++;
      $display("FAIL %s: mode=%0d tx=%0b rx=%0b err=%0b lo=%h hi=%h exp mode=%0d err=%0b lo=%h hi=%h",
               tag, mode, tx_en, rx_en, err, thr_lo, thr_hi, e_mode, e_err, e_lo, e_hi);
    end
  endtask

  task automatic apply(input logic [2:0] r, input logic a, b, c, d, s, f, frc, x,
                       input logic [THR_W-1:0] l, h, input logic strobe, input string tag);
    req = r; lpz = a; lasy = b; ppz = c; pasy = d; strict = s; fdx = f; forced = frc;
    xon = x; lw = l; hw = h; resolve = strobe;
    if (strobe) begin
      if (r > 3'd4) e_err = 1'b1;
      else begin
        e_err = 1'b0;
        e_mode = model(r, a, b, c, d, s, f, frc);
        e_lo = e_mode[1] ? {x, l} : '0;
        e_hi = e_mode[1] ? h : '0;
      end
    end
    @(posedge clk);
    @(negedge clk);
    resolve = 1'b0;
    check(tag);
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: run did not complete, exp finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    rst = 1'b1; resolve = 1'b0; req = '0; lpz = 0; lasy = 0; ppz = 0; pasy = 0;
    strict = 0; fdx = 1; forced = 0; xon = 0; lw = '0; hw = '0;
    e_mode = 2'd0; e_err = 1'b0; e_lo = '0; e_hi = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset");

    // R3 both pause: full request and default give full, rx request gives rx
    apply(3'd3, 1,0,1,0, 0,1,0, 1, 16'h0123, 16'h0456, 1, "R3 full req");
    apply(3'd4, 1,1,1,1, 0,1,0, 0, 16'h0aaa, 16'h0bbb, 1, "R3 R2 default as full");
    apply(3'd1, 1,1,1,0, 0,1,0, 1, 16'h0011, 16'h0022, 1, "R3 rx req");
    apply(3'd2, 1,0,1,1, 0,1,0, 1, 16'h0011, 16'h0022, 1, "R3 tx req gives rx");
    // R4, R10 with xon
    apply(3'd3, 0,1,1,1, 0,1,0, 1, 16'h1234, 16'h5678, 1, "R4 R10 tx only");
    // R11 hold without strobe
    apply(3'd0, 1,1,1,1, 0,0,0, 0, 16'hffff, 16'hffff, 0, "R11 hold");
    // R5
    apply(3'd0, 1,1,0,1, 0,1,0, 0, 16'h0001, 16'h0002, 1, "R5 rx only");
    // R6 fallback
    apply(3'd3, 0,0,0,0, 0,1,0, 0, 16'h0001, 16'h0002, 1, "R6 lenient rx");
    apply(3'd3, 0,0,0,0, 1,1,0, 0, 16'h0001, 16'h0002, 1, "R6 strict none");
    apply(3'd2, 1,1,0,0, 0,1,0, 0, 16'h0001, 16'h0002, 1, "R6 tx req none");
    // R7 half duplex
    apply(3'd3, 1,1,1,1, 0,1,0, 0, 16'h0077, 16'h0088, 1, "R7 setup full");
    apply(3'd3, 1,1,1,1, 0,0,0, 0, 16'h0077, 16'h0088, 1, "R7 half none");
    // R8 forced ignores table and duplex
    apply(3'd2, 1,1,1,1, 1,0,1, 1, 16'h0c0c, 16'h0d0d, 1, "R8 forced tx");
    apply(3'd4, 0,0,0,0, 1,0,1, 0, 16'h0c0c, 16'h0d0d, 1, "R8 forced default");
    // R9 invalid holds
    apply(3'd6, 0,1,1,1, 0,1,0, 0, 16'h0000, 16'h0000, 1, "R9 invalid hold");
    apply(3'd7, 0,0,0,0, 0,0,1, 1, 16'h0101, 16'h0202, 1, "R9 invalid forced");
    apply(3'd1, 0,0,0,0, 0,1,1, 0, 16'h0101, 16'h0202, 1, "R9 valid clears");

    for (int i = 0; i < 400; i++) begin
      logic [7:0] rnd;
      rnd = 8'($urandom);
      apply(3'($urandom_range(0, 7)), rnd[0], rnd[1], rnd[2], rnd[3], rnd[4],
            ($urandom_range(0, 3) != 0), ($urandom_range(0, 4) == 0), rnd[5],
            THR_W'($urandom), THR_W'($urandom), ($urandom_range(0, 5) != 0),
            "R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 random");
    end

    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    e_mode = 2'd0; e_err = 1'b0; e_lo = '0; e_hi = '0;
    check("R1 reset again");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule